// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block decides when a processor is held in reset. Two causes are handled. The first is a "supply low" flag, which comes from an external comparator. The second is a watchdog: it expects the processor to toggle a kick line, and it resets the processor when the line stops changing. Everything is counted in cycles of a single timebase clock. The clock, the comparator and the detection of a floating kick line all sit outside the block and reach it as digital inputs.

The block drives two reset outputs, one active-low and one active-high, which are always inverses of each other. It also drives an active-low watchdog-fault flag. After a reset is released, the watchdog first waits a long period. Once the first kick arrives, it switches to the normal period. A mode input selects what the normal period is. With the mode at 0, the normal period equals the long one. With the mode at 1, the normal period is the shorter one.

A fault holds the fault flag low past the end of the reset pulse, until the kick line changes again. If the kick line stays stuck, the block produces a steady train of reset pulses.

The controller has four states:
- HOLD: reset is asserted while the hold time is counted.
- FIRST: the watchdog runs the long period that follows a reset.
- RUN: the watchdog runs the normal period.
- IDLE: the watchdog is disabled because the kick line floats.

The transitions are:
- HOLD→FIRST when the hold time expires.
- FIRST→RUN and RUN→RUN on a kick edge, which also restarts the count.
- FIRST→HOLD and RUN→HOLD when the period expires.
- Any state→HOLD while supply low is set.
- FIRST→IDLE and RUN→IDLE while the kick line floats.
- IDLE→RUN when the kick line stops floating.

Top module: `proc_supervisor`

## Requirements
- R1: While the asynchronous reset `arst_n` is low, `rst_o`=1, `rst_n_o`=0 and `wdt_fault_n`=1. After `arst_n` is released with `supply_low`=0, reset stays asserted for exactly HOLD_CYCLES clock cycles.
- R2: Setting `supply_low` to 1 asserts `rst_o` in the same cycle, with no clock edge needed, whatever the watchdog state. Reset then stays asserted for as long as `supply_low` is 1.
- R3: Once `supply_low` returns to 0, `rst_o` stays 1 for exactly HOLD_CYCLES rising edges and then falls. The hold count restarts from zero whenever `supply_low` is seen high.
- R4: `rst_n_o` is always the logical inverse of `rst_o`.
- R5: After reset is released, the first watchdog period is WD_LONG_CYCLES edges. If the kick line does not change in that time, reset asserts again on that edge.
- R6: Any level change on `kick`, rising or falling, acts on the third rising edge after the change, because of two synchronizer flops and one previous-value flop. On that edge it restarts the watchdog count and selects the normal period.
- R7: The normal period is WD_NORMAL_CYCLES when `wd_quick_mode`=1 and WD_LONG_CYCLES when `wd_quick_mode`=0.
- R8: When a watchdog period expires, `wdt_fault_n` goes to 0 and reset asserts for HOLD_CYCLES cycles.
- R9: `wdt_fault_n` stays 0 after the reset pulse ends. It returns to 1 only on the edge where a kick transition takes effect (or under R11).
- R10: If `kick` never changes, reset pulses repeat with a period of HOLD_CYCLES + WD_LONG_CYCLES cycles.
- R11: While `kick_float` or `supply_low` is 1, the watchdog does not expire and `wdt_fault_n` reads 1. When `kick_float` clears, a normal period starts from zero on the next edge.
- R12: If a kick edge takes effect on the same edge on which the period would expire, the kick wins. No reset is issued, and the fault flag stays or returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| arst_n | input | 1 | Asynchronous system reset, active low |
| supply_low | input | 1 | Supply below threshold, from the comparator |
| kick | input | 1 | Watchdog kick line, asynchronous |
| kick_float | input | 1 | Kick line is floating, which disables the watchdog |
| wd_quick_mode | input | 1 | 1: short normal period; 0: normal period equals the long period |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| wdt_fault_n | output | 1 | Watchdog fault flag, active low |

## Verification
The kick-edge restart and the period expiry can land on the same clock edge. The bench provokes this by toggling `kick` exactly three edges before the first-period expiry edge, so that the synchronized edge is consumed on the terminal count. The result is judged by requiring `rst_o` to stay 0 on that edge and the next, and `wdt_fault_n` to return to 1. A second overlap is also tested. Here `supply_low` rises while the watchdog is running, and the bench checks that reset appears within the same cycle, ahead of any watchdog decision.

// File: rtl/sv_pkg.sv
package sv_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_FIRST = 2'd1,
        ST_RUN   = 2'd2,
        ST_IDLE  = 2'd3
    } sup_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sv_kick_detect.sv
module sv_kick_detect (
    input  logic clk,
    input  logic arst_n,
    input  logic kick,
    output logic kick_edge
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= kick;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign kick_edge = sync_q ^ prev_q;

endmodule

// File: rtl/sv_cycle_timer.sv
module sv_cycle_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en)
            cnt <= cnt + 1'b1;
    end

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/sv_seq_fsm.sv
module sv_seq_fsm
    import sv_pkg::*;
#(
    parameter int HOLD_CYCLES      = 2048,
    parameter int WD_NORMAL_CYCLES = 1024,
    parameter int WD_LONG_CYCLES   = 4096,
    parameter int CW               = 13
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          supply_low,
    input  logic          kick_float,
    input  logic          kick_edge,
    input  logic          quick_mode,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_en,
    output logic          hold_rst,
    output logic          fault_q
);
    localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] NORMAL_LAST = CW'(WD_NORMAL_CYCLES - 1);
    localparam logic [CW-1:0] LONG_LAST   = CW'(WD_LONG_CYCLES - 1);

    sup_state_t    state_q, state_d;
    logic [CW-1:0] wd_last;
    logic          expire;

    always_comb begin
        if (state_q == ST_FIRST)
            wd_last = LONG_LAST;
        else
            wd_last = quick_mode ? NORMAL_LAST : LONG_LAST;
    end

    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_en  = 1'b0;
        expire  = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (supply_low) begin
                    cnt_clr = 1'b1;
                end else if (cnt == HOLD_LAST) begin
                    state_d = ST_FIRST;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            ST_FIRST, ST_RUN: begin
                if (supply_low) begin
                    state_d = ST_HOLD;
                    cnt_clr = 1'b1;
                end else if (kick_float) begin
                    state_d = ST_IDLE;
                    cnt_clr = 1'b1;
                end else if (kick_edge) begin
                    state_d = ST_RUN;
                    cnt_clr = 1'b1;
                end else if (cnt == wd_last) begin
                    state_d = ST_HOLD;
                    cnt_clr = 1'b1;
                    expire  = 1'b1;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (supply_low)
                    state_d = ST_HOLD;
                else if (!kick_float)
                    state_d = ST_RUN;
            end
            default: begin
                state_d = ST_HOLD;
                cnt_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            fault_q <= 1'b1;
        else if (supply_low || kick_float || kick_edge)
            fault_q <= 1'b1;
        else if (expire)
            fault_q <= 1'b0;
    end

    always_comb begin
        hold_rst = (state_q == ST_HOLD);
    end

    // R2
    supply_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        supply_low |=> (state_q == ST_HOLD));

    // R8
    fault_fall_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(fault_q) |-> (state_q == ST_HOLD));

    // R9
    fault_rise_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(fault_q) |-> $past(kick_edge || supply_low || kick_float));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_FIRST) |-> (cnt <= LONG_LAST));

    // R11
    idle_count_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_IDLE) |=> (cnt == '0));

endmodule

// File: rtl/proc_supervisor.sv
module proc_supervisor
    import sv_pkg::*;
#(
    parameter int HOLD_CYCLES      = 2048,
    parameter int WD_NORMAL_CYCLES = 1024,
    parameter int WD_LONG_CYCLES   = 4096
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_low,
    input  logic kick,
    input  logic kick_float,
    input  logic wd_quick_mode,
    output logic rst_n_o,
    output logic rst_o,
    output logic wdt_fault_n
);
    localparam int MAXC = max3(HOLD_CYCLES, WD_NORMAL_CYCLES, WD_LONG_CYCLES);
    localparam int CW   = $clog2(MAXC + 1);

    logic          kick_edge;
    logic          cnt_clr, cnt_en, hold_rst, fault_q;
    logic [CW-1:0] cnt;

    sv_kick_detect u_kick (
        .clk       (clk),
        .arst_n    (arst_n),
        .kick      (kick),
        .kick_edge (kick_edge)
    );

    sv_cycle_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .arst_n (arst_n),
        .clr    (cnt_clr),
        .en     (cnt_en),
        .cnt    (cnt)
    );

    sv_seq_fsm #(
        .HOLD_CYCLES      (HOLD_CYCLES),
        .WD_NORMAL_CYCLES (WD_NORMAL_CYCLES),
        .WD_LONG_CYCLES   (WD_LONG_CYCLES),
        .CW               (CW)
    ) u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .supply_low (supply_low),
        .kick_float (kick_float),
        .kick_edge  (kick_edge),
        .quick_mode (wd_quick_mode),
        .cnt        (cnt),
        .cnt_clr    (cnt_clr),
        .cnt_en     (cnt_en),
        .hold_rst   (hold_rst),
        .fault_q    (fault_q)
    );

    assign rst_o       = hold_rst | supply_low;
    assign rst_n_o     = ~rst_o;
    assign wdt_fault_n = fault_q | supply_low | kick_float;

    // R4
    rst_pair_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (rst_o != rst_n_o));

    // R11
    float_fault_chk: assert property (@(posedge clk) disable iff (!arst_n)
        kick_float |-> wdt_fault_n);

endmodule

// File: tb/tb_proc_supervisor.sv
module tb_proc_supervisor;

    localparam int H = 8;
    localparam int S = 12;
    localparam int L = 30;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_low = 1'b0;
    logic kick = 1'b0;
    logic kick_float = 1'b0;
    logic wd_quick_mode = 1'b1;
    logic rst_n_o, rst_o, wdt_fault_n;

    always #10 clk = ~clk;

    proc_supervisor #(
        .HOLD_CYCLES(H), .WD_NORMAL_CYCLES(S), .WD_LONG_CYCLES(L)
    ) dut (
        .clk(clk), .arst_n(arst_n), .supply_low(supply_low), .kick(kick),
        .kick_float(kick_float), .wd_quick_mode(wd_quick_mode),
        .rst_n_o(rst_n_o), .rst_o(rst_o), .wdt_fault_n(wdt_fault_n)
    );

    typedef struct {
        int    cyc;
        bit    rst;
        bit    fault_n;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_err = 0;
    bit   drv_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic push(input int c, input bit r, input bit f, input string tag);
        exp_t e;
        e.cyc = c; e.rst = r; e.fault_n = f; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic toggle_kick();
        kick = ~kick;
    endtask

    // monitor: samples 5 ns after each rising edge
    always @(posedge clk) begin
        #5;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            if (e.cyc < cyc)
                chk(1'b0, {e.tag, " missed"}, cyc, e.cyc);
            else begin
                chk(rst_o == e.rst, {e.tag, " rst_o"}, int'(rst_o), int'(e.rst));
                chk(wdt_fault_n == e.fault_n, {e.tag, " wdt_fault_n"},
                    int'(wdt_fault_n), int'(e.fault_n));
                chk(rst_n_o == !rst_o, "R4 rst_n_o", int'(rst_n_o), int'(!rst_o));
            end
        end
    end

    // driver
    initial begin
        int c0, r, r2, k, rel, t1, t2, s, u, v, w;
        @(negedge clk);
        push(cyc + 1, 1'b1, 1'b1, "R1 in reset");
        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        c0 = cyc;
        push(c0 + H - 1, 1'b1, 1'b1, "R1 hold end-1");
        push(c0 + H,     1'b0, 1'b1, "R1 released");

        // R5 R8 R9 R10: no kicks
        r = c0 + H;
        push(r + L - 1,         1'b0, 1'b1, "R5 before expiry");
        push(r + L,             1'b1, 1'b0, "R5 R8 expiry");
        push(r + L + H - 1,     1'b1, 1'b0, "R8 hold");
        push(r + L + H,         1'b0, 1'b0, "R9 fault stays low");
        push(r + 2*L + H - 1,   1'b0, 1'b0, "R10 before 2nd pulse");
        push(r + 2*L + H,       1'b1, 1'b0, "R10 second pulse");
        r2 = r + 2*L + 2*H;

        // R6 R7 R9: kicks, quick mode
        wait_to(r2 + 2);
        k = cyc;
        toggle_kick();
        push(k + 2, 1'b0, 1'b0, "R6 before edge acts");
        push(k + 3, 1'b0, 1'b1, "R9 fault cleared by kick");
        wait_to(k + 10); toggle_kick();
        wait_to(k + 20); toggle_kick();
        push(k + 30, 1'b0, 1'b1, "R6 kicks keep reset off");
        wait_to(k + 30); toggle_kick();
        push(k + 33 + S - 1, 1'b0, 1'b1, "R7 short period not yet");
        push(k + 33 + S,     1'b1, 1'b0, "R7 short period expiry");

        // R7: normal period equals long period in mode 0
        wait_to(k + 33 + S + 1);
        wd_quick_mode = 1'b0;
        rel = k + 33 + S + H;
        push(rel - 1, 1'b1, 1'b0, "R8 hold mode0");
        push(rel,     1'b0, 1'b0, "R8 release mode0");
        wait_to(rel + 2);
        t1 = cyc;
        toggle_kick();
        push(t1 + 3,         1'b0, 1'b1, "R6 kick mode0");
        push(t1 + 3 + S + 2, 1'b0, 1'b1, "R7 mode0 no short expiry");
        push(t1 + 3 + L - 1, 1'b0, 1'b1, "R7 mode0 before long");
        push(t1 + 3 + L,     1'b1, 1'b0, "R7 mode0 long expiry");

        // R12: kick edge on the expiry edge
        t2 = t1 + 3 + L + H;
        push(t2, 1'b0, 1'b0, "R9 release before collision");
        wait_to(t2 + L - 3);
        toggle_kick();
        push(t2 + L - 1, 1'b0, 1'b0, "R12 before collision");
        push(t2 + L,     1'b0, 1'b1, "R12 kick wins expiry");
        push(t2 + L + 1, 1'b0, 1'b1, "R12 no reset after");

        // R2 R3: supply low while running
        s = t2 + L + 5;
        wait_to(s);
        supply_low = 1'b1;
        #1;
        chk(rst_o == 1'b1, "R2 immediate rst_o", int'(rst_o), 1);
        chk(rst_n_o == 1'b0, "R2 immediate rst_n_o", int'(rst_n_o), 0);
        push(s + 1,  1'b1, 1'b1, "R2 supply low");
        push(s + 10, 1'b1, 1'b1, "R2 R11 supply low held");
        u = s + 20;
        wait_to(u);
        supply_low = 1'b0;
        push(u + H - 1, 1'b1, 1'b1, "R3 hold end-1");
        push(u + H,     1'b0, 1'b1, "R3 released");

        // R11: floating kick line
        v = u + H;
        wait_to(v + 2);
        kick_float = 1'b1;
        push(v + 2 + L + 5, 1'b0, 1'b1, "R11 float no expiry");
        w = v + 2 + L + 10;
        wait_to(w);
        kick_float = 1'b0;
        push(w + L,     1'b0, 1'b1, "R11 restart before expiry");
        push(w + L + 1, 1'b1, 1'b0, "R11 restart expiry");
        wait_to(w + L + 3);
        kick_float = 1'b1;
        push(w + L + 4, 1'b1, 1'b1, "R11 float forces fault high");
        wait_to(w + L + 10);
        drv_done = 1'b1;
    end

    // end of run and watchdog
    initial begin
        int guard;
        guard = 0;
        while (!(drv_done && q.size() == 0) && guard < 20000) begin
            @(posedge clk);
            guard++;
        end
        if (guard >= 20000) chk(1'b0, "watchdog expired", guard, 0);
        #7;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule